// File: doc/BRIEF.md
# FIFO Half-Full Burst Drain

This block sits between an external byte-wide FIFO and a local-bus bridge that carries data toward a host as DMA bursts. It watches the FIFO's active-low half-full flag. When that flag drops, it drains exactly one fixed-size packet, which is half the FIFO depth in bytes. It packs the bytes into 32-bit words and hands them to the bridge as one burst. The bridge uses a valid/ready handshake, and the final word of the packet is marked.

Each byte is read with a one-cycle active-low strobe. The byte is captured at the clock edge that ends the strobe. While the FIFO reports empty, no strobe is issued, so a packet that runs dry part-way simply pauses. The block also stops reading when the bridge holds back and a finished word has nowhere to go. After power-up it starts working without any command. Because it drains a half-depth packet on each half-full event, the FIFO cannot overflow as long as the bridge keeps pace.

Top module: `fifo_burst_drain`

## Requirements
- R1: After reset, the read strobe `fifo_rd_n` is high (idle), and both `out_valid` and `out_last` are low.
- R2: The half-full input `fifo_half_n` (low = at least half full) passes through two synchronising flops. With the FIFO non-empty, the first read strobe goes low after the fourth rising edge that follows the flag going low, and not before.
- R3: Each trigger drains exactly PKT_BYTES = FIFO_DEPTH/2 bytes, delivered as PKT_BYTES/4 words.
- R4: Words are packed little-endian. The first byte read of a word lands in bits 7:0, then 15:8, then 23:16, and the fourth byte lands in bits 31:24.
- R5: `out_last` is high on the final word of each packet and low on every other word.
- R6: Once `out_valid` is high, it stays high with `out_data` and `out_last` unchanged until `out_ready` is high at a clock edge. While a finished word waits, the block reads no more than the three bytes of the next word.
- R7: No read strobe is issued while `fifo_empty_n` is low. A packet that meets an empty FIFO pauses and resumes with no byte lost or repeated.
- R8: The half-full flag is ignored while a packet is in progress. After the last word is accepted, a flag that is still low starts a new packet. A flag that is high leaves the block idle, with no reads.
- R9: The read strobe is low for one cycle at a time, with at least one high cycle between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_half_n | input | 1 | FIFO half-full flag, active low, asynchronous |
| fifo_empty_n | input | 1 | FIFO empty flag, active low, synchronous to clk |
| fifo_data | input | 8 | FIFO read data, valid while the strobe is low |
| fifo_rd_n | output | 1 | FIFO read strobe, active low, registered |
| out_data | output | 32 | Packed word toward the bridge |
| out_valid | output | 1 | Word on out_data is valid |
| out_last | output | 1 | Word is the last of the packet |
| out_ready | input | 1 | Bridge accepts the word at this edge |

## Verification
The bench drives inputs and samples outputs on falling edges. The one timed result is the start of reads: the strobe must still be high after the third rising edge that follows a drop of the half-full flag, and low after the fourth. The bench checks both of those edges. All other results depend on how fast bytes flow, at two cycles per byte plus any stalls. For these, the bench records every accepted word at the rising edge where valid and ready are both high, and every strobe at the edge that pops the FIFO model. It compares the totals and contents only after the block has been given enough cycles to settle. For stalls, it counts reads at a point where the block has been blocked for many cycles, so the exact count (seven under backpressure, six on an empty FIFO) is already final.

// File: rtl/drain_pkg.sv
package drain_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_CAPT  = 2'd2,
    ST_FLUSH = 2'd3
  } drain_state_t;
endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic flag_n_async,
  output logic flag_seen
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], flag_n_async};
  end

  assign flag_seen = ~chain_q[STAGES-1];
endmodule

// File: rtl/word_packer.sv
module word_packer #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [BYTE_W-1:0] cap_byte,
  input  logic              cap_final,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_last,
  output logic              slot_free,
  output logic              burst_done
);
  localparam int LANES = WORD_W / BYTE_W;
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [IDX_W-1:0] TOP_LANE = IDX_W'(LANES - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [WORD_W-1:0] asm_q;
  logic [WORD_W-1:0] word_next;

  always_comb begin
    word_next = asm_q;
    word_next[idx_q*BYTE_W +: BYTE_W] = cap_byte;
  end

  assign slot_free  = (idx_q != TOP_LANE) || !out_valid;
  assign burst_done = out_valid && out_ready && out_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      asm_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
        out_last  <= 1'b0;
      end
      if (cap_en) begin
        if (idx_q == TOP_LANE) begin
          out_data  <= word_next;
          out_valid <= 1'b1;
          out_last  <= cap_final;
          idx_q     <= '0;
        end else begin
          asm_q <= word_next;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

  assert_last_whole_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> (idx_q == '0));

  assert_no_overwrite_R6: assert property (@(posedge clk) disable iff (rst)
    (cap_en && idx_q == TOP_LANE) |-> !out_valid);
endmodule

// File: rtl/drain_ctrl.sv
module drain_ctrl
  import drain_pkg::*;
#(
  parameter int PKT_BYTES = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic half_seen,
  input  logic fifo_empty_n,
  input  logic slot_free,
  input  logic burst_done,
  output logic fifo_rd_n,
  output logic cap_en,
  output logic cap_final
);
  localparam int CNT_W = $clog2(PKT_BYTES + 1);

  drain_state_t state_q;
  logic [CNT_W-1:0] left_q;

  assign cap_en    = (state_q == ST_CAPT);
  assign cap_final = (left_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      left_q    <= '0;
      fifo_rd_n <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (half_seen) begin
            left_q  <= CNT_W'(PKT_BYTES);
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (fifo_empty_n && slot_free) begin
            fifo_rd_n <= 1'b0;
            state_q   <= ST_CAPT;
          end
        end
        ST_CAPT: begin
          fifo_rd_n <= 1'b1;
          left_q    <= left_q - 1'b1;
          state_q   <= cap_final ? ST_FLUSH : ST_READ;
        end
        ST_FLUSH: begin
          if (burst_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_no_read_empty_R7: assert property (@(posedge clk) disable iff (rst)
    !fifo_rd_n |-> fifo_empty_n);

  assert_strobe_width_R9: assert property (@(posedge clk) disable iff (rst)
    !fifo_rd_n |=> fifo_rd_n);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE || state_q == ST_FLUSH) |-> fifo_rd_n);

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |-> (left_q <= CNT_W'(PKT_BYTES)));
endmodule

// File: rtl/fifo_burst_drain.sv
module fifo_burst_drain #(
  parameter int FIFO_DEPTH = 2048,
  parameter int WORD_W     = 32,
  parameter int BYTE_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifo_half_n,
  input  logic              fifo_empty_n,
  input  logic [BYTE_W-1:0] fifo_data,
  output logic              fifo_rd_n,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_last,
  input  logic              out_ready
);
  localparam int PKT_BYTES = FIFO_DEPTH / 2;

  logic half_seen;
  logic slot_free;
  logic burst_done;
  logic cap_en;
  logic cap_final;

  flag_sync #(.STAGES(2)) u_sync (
    .clk          (clk),
    .rst          (rst),
    .flag_n_async (fifo_half_n),
    .flag_seen    (half_seen)
  );

  drain_ctrl #(.PKT_BYTES(PKT_BYTES)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .half_seen    (half_seen),
    .fifo_empty_n (fifo_empty_n),
    .slot_free    (slot_free),
    .burst_done   (burst_done),
    .fifo_rd_n    (fifo_rd_n),
    .cap_en       (cap_en),
    .cap_final    (cap_final)
  );

  word_packer #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .cap_en     (cap_en),
    .cap_byte   (fifo_data),
    .cap_final  (cap_final),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .out_last   (out_last),
    .slot_free  (slot_free),
    .burst_done (burst_done)
  );
endmodule

// File: tb/tb_fifo_burst_drain.sv
module tb_fifo_burst_drain;
  localparam int DEPTH = 32;
  localparam int HALF  = DEPTH / 2;
  localparam int WPP   = HALF / 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_half_n, fifo_empty_n, fifo_rd_n;
  logic [7:0] fifo_data;
  logic [31:0] out_data;
  logic out_valid, out_last;
  logic out_ready = 1'b1;

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  logic [7:0] mem [0:255];
  logic [7:0] exp_b [0:255];
  int head = 0, tail = 0, count = 0, rd_cnt = 0, exp_n = 0;
  int low_run = 0, strobe_bad = 0;
  logic [31:0] rx_data [0:63];
  logic rx_last [0:63];
  int rx_n = 0;
  logic hf_ovr = 1'b0, hf_val = 1'b1;

  assign fifo_half_n  = hf_ovr ? hf_val : !(count >= HALF);
  assign fifo_empty_n = (count != 0);
  assign fifo_data    = mem[head[7:0]];

  fifo_burst_drain #(.FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .fifo_half_n(fifo_half_n), .fifo_empty_n(fifo_empty_n),
    .fifo_data(fifo_data), .fifo_rd_n(fifo_rd_n), .out_data(out_data),
    .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready));

  always @(posedge clk) begin
    if (!rst && !fifo_rd_n) begin
      low_run = low_run + 1;
      if (low_run > 1) strobe_bad = strobe_bad + 1;
      if (count > 0) begin
        head = head + 1; count = count - 1; rd_cnt = rd_cnt + 1;
      end
    end else low_run = 0;
    if (!rst && out_valid && out_ready && rx_n < 64) begin
      rx_data[rx_n] = out_data; rx_last[rx_n] = out_last; rx_n = rx_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int n, input int base);
    for (int k = 0; k < n; k++) begin
      mem[tail[7:0]] = 8'(base + k); exp_b[exp_n[7:0]] = 8'(base + k);
      tail = tail + 1; count = count + 1; exp_n = exp_n + 1;
    end
  endtask

  task automatic wait_words(input int n);
    for (int k = 0; k < 2000 && rx_n < n; k++) @(negedge clk);
  endtask

  task automatic check_words(input int from, input int to, input string req);
    for (int j = from; j < to; j++) begin
      logic [31:0] e;
      e = {exp_b[4*j+3], exp_b[4*j+2], exp_b[4*j+1], exp_b[4*j]};
      check(rx_data[j] == e, req, "word data", rx_data[j], e);
      check(rx_last[j] == ((j % WPP) == WPP - 1), "R5", "last flag",
            rx_last[j], (j % WPP) == WPP - 1);
    end
  endtask

  task automatic t_reset;
    check(fifo_rd_n == 1'b1, "R1", "strobe idle", fifo_rd_n, 1);
    check(out_valid == 1'b0, "R1", "valid low", out_valid, 0);
    check(out_last == 1'b0, "R1", "last low", out_last, 0);
  endtask

  task automatic t_trigger;
    push(HALF + 4, 8'h10);
    for (int e = 1; e <= 3; e++) begin
      @(negedge clk);
      check(fifo_rd_n == 1'b1, "R2", "strobe early", fifo_rd_n, 1);
    end
    @(negedge clk);
    check(fifo_rd_n == 1'b0, "R2", "strobe on fourth edge", fifo_rd_n, 0);
    wait_words(WPP);
    repeat (60) @(negedge clk);
    check(rx_n == WPP, "R3", "words per packet", rx_n, WPP);
    check(rd_cnt == HALF, "R3", "bytes per packet", rd_cnt, HALF);
    check(count == 4, "R8", "leftover untouched", count, 4);
    check_words(0, WPP, "R4");
  endtask

  task automatic t_backpressure;
    logic [31:0] held;
    int r0, w0;
    r0 = rd_cnt; w0 = rx_n;
    @(negedge clk); out_ready = 1'b0;
    push(HALF - 4, 8'h40);
    for (int k = 0; k < 200 && !out_valid; k++) @(negedge clk);
    held = out_data;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      check(out_valid && out_data == held, "R6", "held word", out_data, held);
    end
    check(rd_cnt - r0 == 7, "R6", "reads while blocked", rd_cnt - r0, 7);
    out_ready = 1'b1;
    wait_words(w0 + WPP);
    repeat (40) @(negedge clk);
    check(rx_n == w0 + WPP, "R3", "words after backpressure", rx_n, w0 + WPP);
    check_words(w0, w0 + WPP, "R4");
  endtask

  task automatic t_empty;
    int r0, w0;
    r0 = rd_cnt; w0 = rx_n;
    check(count == 0, "R7", "fifo drained before test", count, 0);
    hf_ovr = 1'b1; hf_val = 1'b0;
    push(6, 8'h80);
    repeat (40) @(negedge clk);
    check(rd_cnt - r0 == 6, "R7", "reads stop at empty", rd_cnt - r0, 6);
    check(fifo_rd_n == 1'b1, "R7", "strobe idle while empty", fifo_rd_n, 1);
    check(rx_n - w0 == 1, "R7", "one word out", rx_n - w0, 1);
    hf_val = 1'b1;
    repeat (5) @(negedge clk);
    push(HALF - 6, 8'hA0);
    wait_words(w0 + WPP);
    repeat (40) @(negedge clk);
    check(rd_cnt - r0 == HALF, "R8", "packet completes after flag rises", rd_cnt - r0, HALF);
    check(rx_n == w0 + WPP, "R7", "words after stall", rx_n, w0 + WPP);
    check_words(w0, w0 + WPP, "R7");
    hf_ovr = 1'b0;
  endtask

  task automatic t_retrigger;
    int r0, w0;
    r0 = rd_cnt; w0 = rx_n;
    push(DEPTH, 8'hC0);
    wait_words(w0 + 2 * WPP);
    repeat (60) @(negedge clk);
    check(rx_n == w0 + 2 * WPP, "R8", "two packets back to back", rx_n, w0 + 2 * WPP);
    check(rd_cnt - r0 == DEPTH, "R8", "bytes over two packets", rd_cnt - r0, DEPTH);
    check_words(w0, w0 + 2 * WPP, "R4");
    check(strobe_bad == 0, "R9", "strobe wider than one cycle", strobe_bad, 0);
  endtask

  bit done = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_trigger();
    t_backpressure();
    t_empty();
    t_retrigger();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule